// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor in which every instruction is fetched, decoded, executed, given its memory access and written back within one clock cycle. It runs a fixed set of nine instructions:

- load word and store word;
- register add, subtract, AND, OR and signed set-on-less-than;
- branch-if-equal;
- an absolute jump.

The core holds its own program counter and a 32 by 32-bit register file. Instructions and data live in two separate word arrays inside the core.

The arrays are filled through a load port, normally while reset is held. Instruction memory and data memory are separate because a single-cycle datapath needs an instruction fetch and a data access in the same cycle. A debug port shows the program counter and one register chosen by a select input. This lets a test harness observe the architectural state without stopping the core.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register becomes 0. Loads and stores have no effect during that cycle.
- R2: Without a taken branch or jump, the program counter advances by 4 each cycle. The instruction is fetched from the instruction word at PC bits [IMEM_AW+1:2].
- R3: Opcode 0 reads rs = instr[25:21] and rt = instr[20:16] and writes rd = instr[15:11]. The funct field instr[5:0] selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR, 0x2A signed less-than giving 1 or 0. Any other funct writes nothing.
- R4: Opcode 35 writes rt with the data word at ((rs + sign-extended instr[15:0]) bits [DMEM_AW+1:2]).
- R5: Opcode 43 writes the value of rt into the data word at that same address. A later load of that word returns it.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended instr[15:0] shifted left by 2); otherwise it is PC + 4.
- R7: Opcode 2 sets the next PC to {PC[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads 0. A write that names it is discarded.
- R9: Any other opcode writes neither registers nor data memory and only advances the PC by 4.
- R10: A register written by one instruction holds the new value for the instruction in the following cycle. The write takes effect at the rising edge that ends the writing instruction.
- R11: When `ld_we` is high at a rising edge, `ld_data` is stored at word `ld_addr`. It goes to data memory when `ld_dmem` is 1 and to instruction memory when it is 0.
- R12: `dbg_pc` shows the current PC. `dbg_reg` shows the register selected by `dbg_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_AW | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| dbg_sel | input | 5 | Register index shown on dbg_reg |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg | output | 32 | Value of the selected register |

## Verification
Two events meet at one clock edge. The first is the write-back of an instruction that produces a register. The second is the operand read of the next instruction, which needs that same register. The test program places a subtract directly after the add whose result it consumes, and then checks the subtract's destination. Its value shows whether the fresh value or the stale one was used. A store followed immediately by a load of the same word is checked the same way for data memory.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND  = 4'b0000,
    ALU_OR   = 4'b0001,
    ALU_ADD  = 4'b0010,
    ALU_SUB  = 4'b0110,
    ALU_SLT  = 4'b0111,
    ALU_NONE = 4'b1111
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    imm_b;
    logic    mem_we;
    logic    mem_rd;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_e fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (fn)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_SLT: return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: return '0;
    endcase
  endfunction

  function automatic alu_fn_e alu_pick(input alu_cls_e cls, input logic [5:0] funct);
    if (cls == CLS_ADD) return ALU_ADD;
    if (cls == CLS_SUB) return ALU_SUB;
    case (funct)
      FN_ADD:  return ALU_ADD;
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_NONE;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc,
                                                    input logic [15:0] off);
    return pc + 32'd4 + (sext16(off) << 2);
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc,
                                                  input logic [25:0] idx);
    return {pc[31:28], idx, 2'b00};
  endfunction

endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  alu_cls_e cls;
  alu_fn_e  fn;

  always_comb begin
    ctl = '0;
    ctl.alu_fn = ALU_NONE;
    cls = CLS_ADD;
    case (opcode)
      OPC_RTYPE: begin
        cls        = CLS_FUNCT;
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
      end
      OPC_LOAD: begin
        ctl.imm_b  = 1'b1;
        ctl.mem_rd = 1'b1;
        ctl.reg_we = 1'b1;
      end
      OPC_STORE: begin
        ctl.imm_b  = 1'b1;
        ctl.mem_we = 1'b1;
      end
      OPC_BEQ: begin
        cls        = CLS_SUB;
        ctl.branch = 1'b1;
      end
      OPC_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
    fn = alu_pick(cls, funct);
    ctl.alu_fn = fn;
    if (opcode == OPC_RTYPE && fn == ALU_NONE) ctl.reg_we = 1'b0;
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter  int NREG = 32,
  parameter  int W    = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];

  // R10: a write lands at the edge and is held for the next instruction
  assert_wr_visible_R10: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

  // R8: a read through any port naming register 0 returns zero
  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0 && ra_c == '0) |=> (rd_c == '0));
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
(
  input  alu_fn_e         fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  assign y    = alu_eval(fn, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import cpu_pkg::*;
#(
  parameter  int IMEM_AW = 6,
  parameter  int DMEM_AW = 6,
  localparam int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  input  logic [4:0]       dbg_sel,
  output logic [31:0]      dbg_pc,
  output logic [31:0]      dbg_reg
);
  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IWORDS];
  logic [XLEN-1:0] dmem [DWORDS];

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, instr;
  logic [4:0]      f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  ctl_t            ctl;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_val, imm_x;
  logic            alu_zero;
  logic [4:0]      wr_idx;
  logic [DMEM_AW-1:0] d_idx;

  // named internal events
  logic br_taken, jmp_taken, ev_store, ev_regwr;

  assign instr = imem[pc_q[IMEM_AW+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];
  assign imm_x = sext16(f_imm);

  cpu_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  assign wr_idx = ctl.dst_rd ? f_rd : f_rt;

  cpu_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .ra_c (dbg_sel),
    .we   (ev_regwr),
    .wa   (wr_idx),
    .wd   (wb_val),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .rd_c (dbg_reg)
  );

  assign alu_b = ctl.imm_b ? imm_x : rt_val;

  cpu_alu u_alu (
    .fn   (ctl.alu_fn),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign d_idx  = alu_y[DMEM_AW+1:2];
  assign wb_val = ctl.mem_rd ? dmem[d_idx] : alu_y;

  assign br_taken  = ctl.branch & alu_zero;
  assign jmp_taken = ctl.jump;
  assign ev_store  = ctl.mem_we & ~rst;
  assign ev_regwr  = ctl.reg_we & ~rst;

  assign pc_plus4 = pc_q + 32'd4;
  always_comb begin
    if (jmp_taken)     pc_next = jump_target(pc_q, instr[25:0]);
    else if (br_taken) pc_next = branch_target(pc_q, f_imm);
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem) dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (ev_store)    dmem[d_idx] <= rt_val;
  end

  assign dbg_pc = pc_q;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], alu_y[1:0], alu_y[XLEN-1:DMEM_AW+2],
                         instr[10:6], ld_addr};

  // R1: reset forces the program counter to zero
  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0));

  // R2: sequential advance when no control transfer happens
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && !jmp_taken) |=> (pc_q == $past(pc_q) + 32'd4));

  // R6: taken branch lands on the word-scaled offset from PC+4
  assert_branch_R6: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc_q == $past(pc_q) + 32'd4 + ($past(imm_x) << 2)));

  // R7: jump keeps the upper PC nibble and takes the 26-bit index
  assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
    jmp_taken |=> (pc_q == {$past(pc_q[31:28]), $past(instr[25:0]), 2'b00}));

  // R5: a store deposits rt into the addressed data word
  assert_store_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_store && !ld_we) |=> (dmem[$past(d_idx)] == $past(rt_val)));

  // R9: a cycle never writes both a register and data memory
  assert_one_sink_R9: assert property (@(posedge clk) disable iff (rst)
    !(ev_store && ev_regwr));
endmodule

// File: tb/sim_onecyc_core.sv
module sim_onecyc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_pc, dbg_reg;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  onecyc_core u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_sel(dbg_sel),
    .dbg_pc(dbg_pc), .dbg_reg(dbg_reg)
  );

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input logic [5:0] fn);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] imm);
    return {op, 5'(s), 5'(t), imm};
  endfunction

  // expected register file after the program settles: {index, value}
  localparam logic [36:0] EXP_REGS [16] = '{
    {5'd0,  32'h0000_0000}, {5'd1,  32'h0000_0005}, {5'd2,  32'h0000_0003},
    {5'd3,  32'hFFFF_FFFE}, {5'd4,  32'h0000_0008}, {5'd5,  32'h0000_0005},
    {5'd6,  32'h0000_0001}, {5'd7,  32'h0000_0007}, {5'd8,  32'h0000_0001},
    {5'd9,  32'h0000_0000}, {5'd10, 32'h0000_0008}, {5'd11, 32'h0000_0000},
    {5'd12, 32'h0000_0000}, {5'd13, 32'h0000_0000}, {5'd14, 32'h0000_0003},
    {5'd15, 32'h0000_0000}
  };

  function automatic string reg_tag(input int i);
    case (i)
      0:  return "R8 reg0 after write";
      1, 2, 3: return "R4 load";
      4:  return "R3 add";
      5:  return "R10 back-to-back sub";
      6:  return "R3 and";
      7:  return "R3 or";
      8, 9: return "R3 signed slt";
      10: return "R5 store then load";
      11, 12: return "R6 skipped by branch";
      13: return "R7 skipped by jump";
      14: return "R4 negative offset";
      default: return "R9 unknown opcode no write";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input bit to_d, input int a, input logic [31:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = to_d; ld_addr = 6'(a); ld_data = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input int r, output logic [31:0] v);
    dbg_sel = 5'(r);
    #1 v = dbg_reg;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prog [22];
    logic [31:0] v;
    prog[0]  = enc_i(6'd35, 0, 1, 16'd0);
    prog[1]  = enc_i(6'd35, 0, 2, 16'd4);
    prog[2]  = enc_i(6'd35, 0, 3, 16'd8);
    prog[3]  = enc_r(1, 2, 4, 6'h20);
    prog[4]  = enc_r(4, 2, 5, 6'h22);
    prog[5]  = enc_r(1, 2, 6, 6'h24);
    prog[6]  = enc_r(1, 2, 7, 6'h25);
    prog[7]  = enc_r(3, 1, 8, 6'h2A);
    prog[8]  = enc_r(1, 3, 9, 6'h2A);
    prog[9]  = enc_r(1, 2, 0, 6'h20);
    prog[10] = enc_i(6'd43, 0, 4, 16'd16);
    prog[11] = enc_i(6'd35, 0, 10, 16'd16);
    prog[12] = enc_i(6'd4, 1, 2, 16'd5);
    prog[13] = enc_i(6'd4, 5, 5, 16'd2);
    prog[14] = enc_r(1, 1, 11, 6'h20);
    prog[15] = enc_r(1, 1, 12, 6'h20);
    prog[16] = {6'd2, 26'd19};
    prog[17] = enc_r(1, 1, 13, 6'h20);
    prog[18] = enc_r(1, 1, 13, 6'h20);
    prog[19] = enc_i(6'h3F, 0, 15, 16'd0);
    prog[20] = enc_i(6'd35, 4, 14, 16'hFFFC);
    prog[21] = enc_i(6'd4, 0, 0, 16'hFFFF);

    // R11: program and data enter through the load port under reset
    for (int i = 0; i < 22; i++) load(1'b0, i, prog[i]);
    load(1'b1, 0, 32'd5);
    load(1'b1, 1, 32'd3);
    load(1'b1, 2, 32'hFFFF_FFFE);
    load(1'b1, 4, 32'hDEAD_BEEF);
    @(negedge clk);
    ld_we = 1'b0;
    step(1);

    // R1 reset state, R12 debug visibility
    chk("R1 pc after reset", dbg_pc, 32'd0);
    peek(1, v); chk("R1 reg1 after reset", v, 32'd0);
    peek(0, v); chk("R12 reg0 debug read", v, 32'd0);

    rst = 1'b0;
    step(1);
    chk("R2 pc +4", dbg_pc, 32'd4);
    peek(1, v); chk("R10 load visible next cycle", v, 32'd5);
    step(11);
    chk("R2 pc at word 12", dbg_pc, 32'd48);
    step(1);
    chk("R6 branch not taken", dbg_pc, 32'd52);
    step(1);
    chk("R6 branch taken", dbg_pc, 32'd64);
    step(1);
    chk("R7 jump target", dbg_pc, 32'd76);
    step(1);
    chk("R9 unknown opcode advances pc", dbg_pc, 32'd80);
    step(1);
    chk("R2 pc at word 21", dbg_pc, 32'd84);
    step(3);
    chk("R6 branch to self", dbg_pc, 32'd84);

    // table walk over the architectural registers
    for (int i = 0; i < 16; i++) begin
      peek(int'(EXP_REGS[i][36:32]), v);
      chk(reg_tag(i), v, EXP_REGS[i][31:0]);
    end

    // reset applied mid-run returns the core to its start state
    @(negedge clk); rst = 1'b1;
    step(1);
    chk("R1 pc after second reset", dbg_pc, 32'd0);
    peek(4, v); chk("R1 reg4 cleared", v, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule